// File: doc/BRIEF.md
# Card Socket Controller Register File

This block is the host-facing register file of a controller for removable-card sockets. The host reaches every register through a pair of byte ports. A write to the index port selects a register. A following access to the data port reads or writes that register. The index carries a chip-select bit, a socket-select bit and a six-bit register offset, so one port pair covers up to two sockets on each of up to two controller chips.

Each socket has a small set of registers:

- a read-only identification byte;
- a live status byte built from the socket's detect, battery, write-protect and ready pins;
- a power control byte;
- an interrupt and general control byte;
- a latched change flag for card presence;
- an interrupt configuration byte;
- a window enable byte.

The power and general control fields drive the socket's output-enable, card-enable, programming-voltage code, card reset and I/O-mode controls. The socket pins pass through a two-flop synchronizer. When the card-present state changes, a flag is latched. Each flag can be steered to a single management interrupt request.

Top module: `cardsock_regfile`

## Requirements
- R1: A write to the index port (hostPort = 0) loads the eight-bit index. A read of the index port returns that index on hostRdata after the clock edge that accepts the read.
- R2: Index bit 7 selects the chip, bit 6 selects the socket and bits 5:0 give the offset. The socket number is chip × SOCKS_PER_CHIP + socket. Offsets other than 0 to 6, and sockets beyond the configured counts, read as 0x00, and writes to them change nothing.
- R3: Offset 0 reads as the identification byte: upper nibble 0x8 and lower nibble REVISION (default 0x2, so 0x82). Writes to it are ignored.
- R4: Offset 1 reads the socket status:
  - bit 7 is 0;
  - bit 6 is 1 when power-control bits 7 and 4 are both set;
  - bit 5 is ready, bit 4 is write protect;
  - bits 3:2 are the two detect pins, bits 1:0 are the two battery pins.

  The status shows the pin levels captured two clock edges before the read edge. Writes are ignored.
- R5: Offset 2 is power control. Bits 7, 5, 4, 1 and 0 are writable and the other bits read 0. Bit 7 drives sockOutEn, bit 4 drives sockCardEn, and bits 1:0 drive the socket's sockVpp code (1 = 5 V, 2 = 12 V).
- R6: Offset 3 is general control. Bits 6, 5 and 3:0 are writable and the other bits read 0. Bit 6 drives sockResetN (the card is held in reset while it is 0), bit 5 drives sockIoMode, and bits 3:0 hold the card IRQ select.
- R7: Offset 4 bit 3 sets when card presence changes. A card is present when both of its synchronized detect pins are 1. A data-port read of offset 4 returns the flag and then clears it, unless a new change arrives in the same cycle. Writes are ignored, and the other bits read 0.
- R8: Offset 5 is interrupt configuration. Bits 7:4 are the management line select and bit 3 is the change-interrupt enable. Bits 2:0 read 0.
- R9: Offset 6 is window enable. Bits 3:0 enable memory windows 0 to 3 and bit 6 enables I/O window 0. The other bits read 0.
- R10: irqReq is high while any socket has its change flag set together with its enable bit (offset 5 bit 3). It follows the flag in the same cycle.
- R11: hostRdata changes only on the clock edge that accepts a read of either port, and holds its value otherwise.
- R12: Reset clears the index, hostRdata, every control register, every change flag and the synchronizers. As a result sockResetN, sockOutEn, sockCardEn, sockVpp, sockIoMode and irqReq are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hostSel | input | 1 | Host access strobe, one cycle per access |
| hostWr | input | 1 | 1 = write, 0 = read |
| hostPort | input | 1 | 0 = index port, 1 = data port |
| hostWdata | input | 8 | Host write data |
| hostRdata | output | 8 | Registered host read data |
| detectIn | input | 2*NUM_SOCK | Two card-detect pins per socket |
| batteryIn | input | 2*NUM_SOCK | Two battery status pins per socket |
| wprotIn | input | NUM_SOCK | Write protect per socket |
| readyIn | input | NUM_SOCK | Card ready per socket |
| sockOutEn | output | NUM_SOCK | Output enable per socket |
| sockCardEn | output | NUM_SOCK | Card enable per socket |
| sockVpp | output | 2*NUM_SOCK | Programming voltage code per socket |
| sockResetN | output | NUM_SOCK | Active-low card reset per socket |
| sockIoMode | output | NUM_SOCK | I/O card mode per socket |
| irqReq | output | 1 | Status-change interrupt request |

## Verification
The assertions assume the following about the host:

- it presents at most one access per cycle;
- it holds hostSel high for exactly one cycle per access;
- only a data-port write may move the socket control outputs;
- only a read may move hostRdata.

The stimulus keeps to these rules by driving the host and pin inputs only on falling edges, through single-cycle access tasks. The pins may change at any time because they are synchronized inside the block. The bench drives only single-pin and paired-pin detect patterns, so presence toggles cleanly.

// File: rtl/cardsock_pkg.sv
package cardsock_pkg;

  localparam int DATA_W    = 8;
  localparam int IDX_W     = 8;
  localparam int OFF_W     = 6;
  localparam int SOCK_ID_W = 2;
  localparam int CHIP_BIT  = 7;
  localparam int SOCK_BIT  = 6;

  localparam logic [OFF_W-1:0] OFF_ID   = 6'd0;
  localparam logic [OFF_W-1:0] OFF_STAT = 6'd1;
  localparam logic [OFF_W-1:0] OFF_PWR  = 6'd2;
  localparam logic [OFF_W-1:0] OFF_GEN  = 6'd3;
  localparam logic [OFF_W-1:0] OFF_CHG  = 6'd4;
  localparam logic [OFF_W-1:0] OFF_CFG  = 6'd5;
  localparam logic [OFF_W-1:0] OFF_WIN  = 6'd6;

  localparam logic [DATA_W-1:0] PWR_MASK = 8'hB3;
  localparam logic [DATA_W-1:0] GEN_MASK = 8'h6F;
  localparam logic [DATA_W-1:0] CFG_MASK = 8'hF8;
  localparam logic [DATA_W-1:0] WIN_MASK = 8'h4F;

  // strobes from the host decoder into the register datapath
  typedef struct packed {
    logic                  idxRd;
    logic                  dataWr;
    logic                  dataRd;
    logic                  hit;
    logic [SOCK_ID_W-1:0]  sockId;
    logic [OFF_W-1:0]      off;
    logic [DATA_W-1:0]     wdata;
  } hostStrobe_t;

  // socket pin sample, laid out as status bits 5:0
  typedef struct packed {
    logic       ready;
    logic       wprot;
    logic [1:0] detect;
    logic [1:0] battery;
  } pinStat_t;

endpackage

// File: rtl/cardsock_ctrl.sv
module cardsock_ctrl
  import cardsock_pkg::*;
#(
  parameter int NUM_CHIPS      = 2,
  parameter int SOCKS_PER_CHIP = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hostSel,
  input  logic              hostWr,
  input  logic              hostPort,
  input  logic [DATA_W-1:0] hostWdata,
  output logic [IDX_W-1:0]  idxReg,
  output hostStrobe_t       strb
);

  logic chipSel;
  logic sockSel;
  int   sockNum;

  always_ff @(posedge clk) begin
    if (rst) begin
      idxReg <= '0;
    end else if (hostSel && hostWr && !hostPort) begin
      idxReg <= hostWdata;
    end
  end

  always_comb begin
    chipSel     = idxReg[CHIP_BIT];
    sockSel     = idxReg[SOCK_BIT];
    sockNum     = int'(chipSel) * SOCKS_PER_CHIP + int'(sockSel);
    strb.idxRd  = hostSel && !hostWr && !hostPort;
    strb.dataWr = hostSel && hostWr && hostPort;
    strb.dataRd = hostSel && !hostWr && hostPort;
    strb.hit    = (int'(chipSel) < NUM_CHIPS) && (int'(sockSel) < SOCKS_PER_CHIP);
    strb.sockId = SOCK_ID_W'(sockNum);
    strb.off    = idxReg[OFF_W-1:0];
    strb.wdata  = hostWdata;
  end

endmodule

// File: rtl/cardsock_dpath.sv
module cardsock_dpath
  import cardsock_pkg::*;
#(
  parameter int         NUM_SOCK = 4,
  parameter logic [3:0] REVISION = 4'h2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  hostStrobe_t           strb,
  input  logic [IDX_W-1:0]      idxReg,
  input  logic [2*NUM_SOCK-1:0] detectIn,
  input  logic [2*NUM_SOCK-1:0] batteryIn,
  input  logic [NUM_SOCK-1:0]   wprotIn,
  input  logic [NUM_SOCK-1:0]   readyIn,
  output logic [DATA_W-1:0]     hostRdata,
  output logic [NUM_SOCK-1:0]   sockOutEn,
  output logic [NUM_SOCK-1:0]   sockCardEn,
  output logic [2*NUM_SOCK-1:0] sockVpp,
  output logic [NUM_SOCK-1:0]   sockResetN,
  output logic [NUM_SOCK-1:0]   sockIoMode,
  output logic                  irqReq
);

  localparam logic [DATA_W-1:0] ID_VALUE = {4'h8, REVISION};

  logic [DATA_W-1:0] sockRead [NUM_SOCK];
  logic [NUM_SOCK-1:0] chgVec;
  logic [NUM_SOCK-1:0] chgEnVec;
  logic [DATA_W-1:0] selRead;

  for (genvar s = 0; s < NUM_SOCK; s++) begin : g_sock
    pinStat_t          rawPin;
    pinStat_t          syncA;
    pinStat_t          syncB;
    logic              presPrev;
    logic              presNow;
    logic              chgEvt;
    logic              chgFlag;
    logic              selThis;
    logic              wrThis;
    logic              clrThis;
    logic [DATA_W-1:0] pwrReg;
    logic [DATA_W-1:0] genReg;
    logic [DATA_W-1:0] cfgReg;
    logic [DATA_W-1:0] winReg;
    logic [DATA_W-1:0] readVal;

    assign rawPin  = {readyIn[s], wprotIn[s], detectIn[2*s +: 2], batteryIn[2*s +: 2]};
    assign presNow = &syncB.detect;
    assign chgEvt  = presNow != presPrev;
    assign selThis = strb.hit && (strb.sockId == SOCK_ID_W'(s));
    assign wrThis  = strb.dataWr && selThis;
    assign clrThis = strb.dataRd && selThis && (strb.off == OFF_CHG);

    // pin synchronizer and presence change latch
    always_ff @(posedge clk) begin
      if (rst) begin
        syncA    <= '0;
        syncB    <= '0;
        presPrev <= 1'b0;
        chgFlag  <= 1'b0;
      end else begin
        syncA    <= rawPin;
        syncB    <= syncA;
        presPrev <= presNow;
        if (chgEvt) begin
          chgFlag <= 1'b1;
        end else if (clrThis) begin
          chgFlag <= 1'b0;
        end
      end
    end

    // writable control registers
    always_ff @(posedge clk) begin
      if (rst) begin
        pwrReg <= '0;
        genReg <= '0;
        cfgReg <= '0;
        winReg <= '0;
      end else if (wrThis) begin
        case (strb.off)
          OFF_PWR: pwrReg <= strb.wdata & PWR_MASK;
          OFF_GEN: genReg <= strb.wdata & GEN_MASK;
          OFF_CFG: cfgReg <= strb.wdata & CFG_MASK;
          OFF_WIN: winReg <= strb.wdata & WIN_MASK;
          default: ;
        endcase
      end
    end

    always_comb begin
      case (strb.off)
        OFF_ID:   readVal = ID_VALUE;
        OFF_STAT: readVal = {1'b0, pwrReg[7] & pwrReg[4], syncB};
        OFF_PWR:  readVal = pwrReg;
        OFF_GEN:  readVal = genReg;
        OFF_CHG:  readVal = {4'b0000, chgFlag, 3'b000};
        OFF_CFG:  readVal = cfgReg;
        OFF_WIN:  readVal = winReg;
        default:  readVal = '0;
      endcase
    end

    assign sockRead[s]        = readVal;
    assign chgVec[s]          = chgFlag;
    assign chgEnVec[s]        = cfgReg[3];
    assign sockOutEn[s]       = pwrReg[7];
    assign sockCardEn[s]      = pwrReg[4];
    assign sockVpp[2*s +: 2]  = pwrReg[1:0];
    assign sockResetN[s]      = genReg[6];
    assign sockIoMode[s]      = genReg[5];
  end

  always_comb begin
    selRead = '0;
    for (int s = 0; s < NUM_SOCK; s++) begin
      if (strb.hit && (strb.sockId == SOCK_ID_W'(s))) begin
        selRead = sockRead[s];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hostRdata <= '0;
    end else if (strb.idxRd) begin
      hostRdata <= idxReg;
    end else if (strb.dataRd) begin
      hostRdata <= selRead;
    end
  end

  assign irqReq = |(chgVec & chgEnVec);

endmodule

// File: rtl/cardsock_regfile.sv
module cardsock_regfile
  import cardsock_pkg::*;
#(
  parameter int         NUM_CHIPS      = 2,
  parameter int         SOCKS_PER_CHIP = 2,
  parameter logic [3:0] REVISION       = 4'h2,
  localparam int        NUM_SOCK       = NUM_CHIPS * SOCKS_PER_CHIP
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  hostSel,
  input  logic                  hostWr,
  input  logic                  hostPort,
  input  logic [7:0]            hostWdata,
  output logic [7:0]            hostRdata,
  input  logic [2*NUM_SOCK-1:0] detectIn,
  input  logic [2*NUM_SOCK-1:0] batteryIn,
  input  logic [NUM_SOCK-1:0]   wprotIn,
  input  logic [NUM_SOCK-1:0]   readyIn,
  output logic [NUM_SOCK-1:0]   sockOutEn,
  output logic [NUM_SOCK-1:0]   sockCardEn,
  output logic [2*NUM_SOCK-1:0] sockVpp,
  output logic [NUM_SOCK-1:0]   sockResetN,
  output logic [NUM_SOCK-1:0]   sockIoMode,
  output logic                  irqReq
);

  logic [IDX_W-1:0] idxReg;
  hostStrobe_t      strb;

  cardsock_ctrl #(
    .NUM_CHIPS      (NUM_CHIPS),
    .SOCKS_PER_CHIP (SOCKS_PER_CHIP)
  ) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .hostSel   (hostSel),
    .hostWr    (hostWr),
    .hostPort  (hostPort),
    .hostWdata (hostWdata),
    .idxReg    (idxReg),
    .strb      (strb)
  );

  cardsock_dpath #(
    .NUM_SOCK (NUM_SOCK),
    .REVISION (REVISION)
  ) u_dpath (
    .clk        (clk),
    .rst        (rst),
    .strb       (strb),
    .idxReg     (idxReg),
    .detectIn   (detectIn),
    .batteryIn  (batteryIn),
    .wprotIn    (wprotIn),
    .readyIn    (readyIn),
    .hostRdata  (hostRdata),
    .sockOutEn  (sockOutEn),
    .sockCardEn (sockCardEn),
    .sockVpp    (sockVpp),
    .sockResetN (sockResetN),
    .sockIoMode (sockIoMode),
    .irqReq     (irqReq)
  );

endmodule

// File: rtl/cardsock_checker.sv
module cardsock_checker #(
  parameter int NUM_SOCK = 4
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  hostSel,
  input logic                  hostWr,
  input logic                  hostPort,
  input logic [7:0]            hostWdata,
  input logic [7:0]            hostRdata,
  input logic [7:0]            idxReg,
  input logic                  dataRd,
  input logic                  hit,
  input logic [5:0]            off,
  input logic [NUM_SOCK-1:0]   sockOutEn,
  input logic [NUM_SOCK-1:0]   sockCardEn,
  input logic [2*NUM_SOCK-1:0] sockVpp,
  input logic [NUM_SOCK-1:0]   sockResetN,
  input logic [NUM_SOCK-1:0]   sockIoMode
);

  a_r1_index_load: assert property (@(posedge clk) disable iff (rst)
    (hostSel && hostWr && !hostPort) |=> (idxReg == $past(hostWdata)));

  a_r3_id_nibble: assert property (@(posedge clk) disable iff (rst)
    (dataRd && hit && off == 6'd0) |=> (hostRdata[7:4] == 4'h8));

  a_r11_rdata_hold: assert property (@(posedge clk) disable iff (rst)
    !(hostSel && !hostWr) |=> $stable(hostRdata));

  a_r5_ctl_by_write: assert property (@(posedge clk) disable iff (rst)
    !(hostSel && hostWr && hostPort) |=>
      $stable({sockOutEn, sockCardEn, sockVpp, sockResetN, sockIoMode}));

endmodule

bind cardsock_regfile cardsock_checker #(.NUM_SOCK(NUM_SOCK)) u_checker (
  .clk        (clk),
  .rst        (rst),
  .hostSel    (hostSel),
  .hostWr     (hostWr),
  .hostPort   (hostPort),
  .hostWdata  (hostWdata),
  .hostRdata  (hostRdata),
  .idxReg     (idxReg),
  .dataRd     (strb.dataRd),
  .hit        (strb.hit),
  .off        (strb.off),
  .sockOutEn  (sockOutEn),
  .sockCardEn (sockCardEn),
  .sockVpp    (sockVpp),
  .sockResetN (sockResetN),
  .sockIoMode (sockIoMode)
);

// File: tb/cardsock_regfile_bench.sv
module cardsock_regfile_bench;

  localparam int NC  = 2;
  localparam int SPC = 2;
  localparam int NS  = NC * SPC;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst;
  logic          hostSel, hostWr, hostPort;
  logic [7:0]    hostWdata, hostRdata;
  logic [2*NS-1:0] detectIn, batteryIn, sockVpp;
  logic [NS-1:0] wprotIn, readyIn, sockOutEn, sockCardEn, sockResetN, sockIoMode;
  logic          irqReq;

  cardsock_regfile #(.NUM_CHIPS(NC), .SOCKS_PER_CHIP(SPC)) u_cardsock_regfile (
    .clk(clk), .rst(rst), .hostSel(hostSel), .hostWr(hostWr), .hostPort(hostPort),
    .hostWdata(hostWdata), .hostRdata(hostRdata), .detectIn(detectIn),
    .batteryIn(batteryIn), .wprotIn(wprotIn), .readyIn(readyIn),
    .sockOutEn(sockOutEn), .sockCardEn(sockCardEn), .sockVpp(sockVpp),
    .sockResetN(sockResetN), .sockIoMode(sockIoMode), .irqReq(irqReq)
  );

  int checks = 0;
  int errors = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  // behavioural reference model
  logic [7:0] mIdx, mRdata;
  logic [7:0] mPwr [NS];
  logic [7:0] mGen [NS];
  logic [7:0] mCfg [NS];
  logic [7:0] mWin [NS];
  logic       mChg [NS];
  logic       mPrev [NS];
  logic [5:0] mS1 [NS];
  logic [5:0] mS2 [NS];
  int         ms;
  logic       mValid, mPres, mEvt, mClr;
  logic [7:0] mRv;

  function automatic logic [7:0] modelRead(input int s, input logic [5:0] off);
    case (off)
      6'd0: return 8'h82;
      6'd1: return {1'b0, mPwr[s][7] & mPwr[s][4], mS2[s]};
      6'd2: return mPwr[s];
      6'd3: return mGen[s];
      6'd4: return {4'b0, mChg[s], 3'b0};
      6'd5: return mCfg[s];
      6'd6: return mWin[s];
      default: return 8'h00;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      mIdx = 0; mRdata = 0;
      for (int k = 0; k < NS; k++) begin
        mPwr[k] = 0; mGen[k] = 0; mCfg[k] = 0; mWin[k] = 0;
        mChg[k] = 0; mPrev[k] = 0; mS1[k] = 0; mS2[k] = 0;
      end
    end else begin
      ms     = int'(mIdx[7]) * SPC + int'(mIdx[6]);
      mValid = (int'(mIdx[7]) < NC) && (int'(mIdx[6]) < SPC);
      mRv    = mValid ? modelRead(ms, mIdx[5:0]) : 8'h00;
      for (int k = 0; k < NS; k++) begin
        mPres = (mS2[k][3:2] == 2'b11);
        mEvt  = (mPres != mPrev[k]);
        mClr  = hostSel && !hostWr && hostPort && mValid && (ms == k) && (mIdx[5:0] == 6'd4);
        if (mEvt) mChg[k] = 1'b1;
        else if (mClr) mChg[k] = 1'b0;
        mPrev[k] = mPres;
        mS2[k] = mS1[k];
        mS1[k] = {readyIn[k], wprotIn[k], detectIn[2*k+1], detectIn[2*k],
                  batteryIn[2*k+1], batteryIn[2*k]};
      end
      if (hostSel) begin
        if (!hostPort) begin
          if (hostWr) mIdx = hostWdata;
          else mRdata = mIdx;
        end else if (!hostWr) begin
          mRdata = mRv;
        end else if (mValid) begin
          case (mIdx[5:0])
            6'd2: mPwr[ms] = hostWdata & 8'hB3;
            6'd3: mGen[ms] = hostWdata & 8'h6F;
            6'd5: mCfg[ms] = hostWdata & 8'hF8;
            6'd6: mWin[ms] = hostWdata & 8'h4F;
            default: ;
          endcase
        end
      end
    end
  end

  // cycle-by-cycle comparison against the model
  logic          eIrq;
  logic [NS-1:0] eOut, eCard, eRst, eIo;
  logic [2*NS-1:0] eVpp;
  always @(negedge clk) begin
    if (!rst) begin
      eIrq = 0;
      for (int k = 0; k < NS; k++) begin
        eIrq |= mChg[k] & mCfg[k][3];
        eOut[k] = mPwr[k][7]; eCard[k] = mPwr[k][4];
        eVpp[2*k +: 2] = mPwr[k][1:0];
        eRst[k] = mGen[k][6]; eIo[k] = mGen[k][5];
      end
      check("R11 model rdata", {24'b0, hostRdata}, {24'b0, mRdata});
      check("R10 model irq", {31'b0, irqReq}, {31'b0, eIrq});
      check("R5 model power", {16'b0, sockOutEn, sockCardEn, sockVpp},
            {16'b0, eOut, eCard, eVpp});
      check("R6 model general", {24'b0, sockResetN, sockIoMode}, {24'b0, eRst, eIo});
    end
  end

  task automatic access(input logic port, input logic wr, input logic [7:0] d);
    hostSel = 1'b1; hostWr = wr; hostPort = port; hostWdata = d;
    @(negedge clk);
    hostSel = 1'b0; hostWr = 1'b0; hostWdata = 8'h00;
  endtask

  task automatic wrIdx(input logic [7:0] d); access(1'b0, 1'b1, d); endtask
  task automatic wrData(input logic [7:0] d); access(1'b1, 1'b1, d); endtask
  task automatic rdIdx(); access(1'b0, 1'b0, 8'h00); endtask
  task automatic rdData(); access(1'b1, 1'b0, 8'h00); endtask

  task automatic finishRun();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  int cycles = 0;
  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual %0d expected below 20000", cycles);
      finishRun();
    end
  end

  initial begin
    rst = 1; hostSel = 0; hostWr = 0; hostPort = 0; hostWdata = 0;
    detectIn = 0; batteryIn = 0; wprotIn = 0; readyIn = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R12 reset state
    check("R12 resetN", {28'b0, sockResetN}, 0);
    check("R12 power", {16'b0, sockOutEn, sockCardEn, sockVpp}, 0);
    check("R12 irq", {31'b0, irqReq}, 0);
    check("R12 rdata", {24'b0, hostRdata}, 0);

    wrIdx(8'h45); rdIdx(); check("R1 index readback", {24'b0, hostRdata}, 8'h45);

    wrIdx(8'h00); rdData(); check("R3 id", {24'b0, hostRdata}, 8'h82);
    wrData(8'hFF); rdData(); check("R3 id write ignored", {24'b0, hostRdata}, 8'h82);

    wrIdx(8'h02); wrData(8'hFF); rdData();
    check("R5 power mask", {24'b0, hostRdata}, 8'hB3);
    check("R5 outEn", {28'b0, sockOutEn}, 4'b0001);
    check("R5 cardEn", {28'b0, sockCardEn}, 4'b0001);
    check("R5 vpp", {24'b0, sockVpp}, 8'h03);
    wrData(8'h21); rdData();
    check("R5 power 5V", {24'b0, hostRdata}, 8'h21);
    check("R5 vpp 5V", {24'b0, sockVpp}, 8'h01);
    check("R5 cardEn off", {28'b0, sockCardEn}, 4'b0000);
    wrData(8'h92);
    check("R5 vpp 12V", {24'b0, sockVpp}, 8'h02);

    wrIdx(8'hC3); wrData(8'hFF); rdData();
    check("R6 general mask", {24'b0, hostRdata}, 8'h6F);
    check("R6 resetN", {28'b0, sockResetN}, 4'b1000);
    check("R6 ioMode", {28'b0, sockIoMode}, 4'b1000);
    wrData(8'h4A); rdData();
    check("R6 general value", {24'b0, hostRdata}, 8'h4A);
    check("R6 ioMode off", {28'b0, sockIoMode}, 4'b0000);

    wrIdx(8'h45); wrData(8'hFF); rdData(); check("R8 config mask", {24'b0, hostRdata}, 8'hF8);
    wrIdx(8'h86); wrData(8'hFF); rdData(); check("R9 window mask", {24'b0, hostRdata}, 8'h4F);

    wrIdx(8'h07); wrData(8'hFF); rdData(); check("R2 unused offset", {24'b0, hostRdata}, 8'h00);
    wrIdx(8'h3F); rdData(); check("R2 top offset", {24'b0, hostRdata}, 8'h00);
    wrIdx(8'h06); rdData(); check("R2 socket0 window untouched", {24'b0, hostRdata}, 8'h00);

    wrIdx(8'h01); rdData(); check("R4 powered only", {24'b0, hostRdata}, 8'h40);

    detectIn[5:4] = 2'b11; batteryIn[5:4] = 2'b11; wprotIn[2] = 1; readyIn[2] = 1;
    repeat (3) @(negedge clk);
    wrIdx(8'h81); rdData(); check("R4 status pins", {24'b0, hostRdata}, 8'h3F);
    wrData(8'hFF); rdData(); check("R4 status write ignored", {24'b0, hostRdata}, 8'h3F);

    wrIdx(8'h84); rdData(); check("R7 change set", {24'b0, hostRdata}, 8'h08);
    check("R10 irq disabled", {31'b0, irqReq}, 0);
    rdData(); check("R7 cleared by read", {24'b0, hostRdata}, 8'h00);
    wrData(8'hFF); rdData(); check("R7 write ignored", {24'b0, hostRdata}, 8'h00);

    wrIdx(8'h85); wrData(8'h08);
    detectIn[5:4] = 2'b01;
    repeat (2) @(negedge clk);
    check("R10 irq not yet", {31'b0, irqReq}, 0);
    @(negedge clk);
    check("R10 irq on removal", {31'b0, irqReq}, 1);
    wrIdx(8'h84); rdData(); check("R7 removal flag", {24'b0, hostRdata}, 8'h08);
    check("R10 irq cleared", {31'b0, irqReq}, 0);

    repeat (4) @(negedge clk);
    wrData(8'hAA);
    check("R11 rdata held", {24'b0, hostRdata}, 8'h08);

    detectIn[3:2] = 2'b11;
    repeat (4) @(negedge clk);
    check("R10 irq socket1", {31'b0, irqReq}, 1);
    wrIdx(8'h44); rdData(); check("R7 socket1 flag", {24'b0, hostRdata}, 8'h08);

    detectIn[7:6] = 2'b10;
    repeat (5) @(negedge clk);
    wrIdx(8'hC4); rdData(); check("R7 one pin no change", {24'b0, hostRdata}, 8'h00);
    wrIdx(8'hC1); rdData(); check("R4 single detect", {24'b0, hostRdata}, 8'h08);

    rst = 1;
    repeat (2) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check("R12 resetN again", {28'b0, sockResetN}, 0);
    check("R12 outEn again", {28'b0, sockOutEn}, 0);
    check("R12 rdata again", {24'b0, hostRdata}, 0);
    check("R12 irq again", {31'b0, irqReq}, 0);
    repeat (6) @(negedge clk);
    finishRun();
  end

endmodule